// File: doc/BRIEF.md
# Waveform Sample Lookup Memory

This block is the phase-to-amplitude stage of a direct digital synthesizer. It keeps one full period of a waveform as 256 samples of 8 bits each. A phase accumulator outside the block supplies its full-width phase word. The top 8 bits of that word pick a sample, and the sample goes to an external DAC. An offset-binary code is used: 00h is one end of the analog range and FFh is the other. The accumulator adds a programmable step on every read clock, so the table address jumps by that step on each sample. A larger step sweeps the table faster and gives a higher output frequency. Each time the address falls back below its previous value, one output period is complete, and the block flags that on a one-cycle wrap pulse.

The table has a write port of its own, with its own clock, address, data and enable. Software-side logic can therefore replace the waveform while the read side keeps running. The block does not need to be loaded before use. When the write-side reset is released, a small state machine copies a computed sine into the table. It has two states. ST_FILL is entered on write reset and walks every address in ascending order, one per write clock. Transition ST_FILL to ST_RUN is taken after the last address is written. ST_RUN hands the memory to the external write port and stays there until the next write reset, which is the only transition back to ST_FILL.

Top module: `wave_lut`

## Requirements
- R1: In ST_RUN, a write clock edge with wr_en high stores wr_data at wr_addr, and later reads of that address return it.
- R2: Reads are synchronous. After each read clock edge, q holds the sample stored at the address that phase selected at that edge.
- R3: The read address is phase[31:24]. Bits 23:0 of phase have no effect on q.
- R4: wrap is high for exactly the cycles in which q shows a sample whose address is lower than the address read at the previous edge. The first sample after a read reset never raises wrap.
- R5: After wrst_n rises, the table is filled within 256 write clocks, one address per clock in ascending order from 0. Address k receives round(128 + 127·sin(2πk/256)).
- R6: wr_en, wr_addr and wr_data are ignored while the fill is running.
- R7: While rrst_n is low, q is 00h and wrap is 0, regardless of the clock.
- R8: A write and a read to the same address in overlapping cycles return either the old or the new sample. Once the write has settled, reads return the new sample.
- R9: With a phase step of 16 addresses per sample, starting from address 0, wrap rises once every 16 samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low; starts the sine fill |
| wr_en | input | 1 | Write enable for the external write port |
| wr_addr | input | 8 | Table address to write |
| wr_data | input | 8 | Sample value to write |
| rclk | input | 1 | Read-side (sample) clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| phase | input | 32 | Phase accumulator output; top 8 bits address the table |
| q | output | 8 | Registered sample to the DAC, offset binary |
| wrap | output | 1 | One-cycle pulse marking a completed output period |

## Verification
The first sweep steps through all 256 addresses right after the power-up fill. This separates a correct sine table and a fill that ignores the write port from a corrupted or overwritten one. A known XOR pattern is then loaded, and the table is swept with several phase steps. The steps are one address, odd steps with noisy low bits, a quarter table, 200 addresses, and minus one. This separates correct address slicing and sample latency from off-by-one-cycle or wrong-bit errors. The large and negative steps also put wrap on many consecutive cycles, which tells a true comparison apart from a pulse generator. A same-address write during reads, a read reset in mid-stream, and a second write reset restoring the sine cover the collision, first-sample and refill cases.

// File: rtl/wave_lut_pkg.sv
package wave_lut_pkg;

    typedef enum logic {
        ST_FILL,
        ST_RUN
    } fill_state_e;

    localparam real TWO_PI = 6.283185307179586;

    // Offset-binary sine level for table slot k of depth slots, dw bits wide.
    function automatic int sine_level(int k, int depth, int dw);
        real mid;
        real ang;
        real val;
        mid = real'(1 << (dw - 1));
        ang = TWO_PI * real'(k) / real'(depth);
        val = mid + (mid - 1.0) * $sin(ang);
        return $rtoi(val + 0.5);
    endfunction

endpackage

// File: rtl/wave_sine_rom.sv
module wave_sine_rom
    import wave_lut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] level
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] table_q [DEPTH];

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            table_q[k] = DATA_W'(sine_level(k, DEPTH, DATA_W));
        end
    end

    assign level = table_q[idx];

endmodule

// File: rtl/wave_fill_ctrl.sv
module wave_fill_ctrl
    import wave_lut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_data,
    output logic              fill_busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    fill_state_e       state_q;
    fill_state_e       state_d;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] idx_d;
    logic [DATA_W-1:0] rom_val;

    wave_sine_rom #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rom (
        .idx  (idx_q),
        .level(rom_val)
    );

    // State register
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            state_q <= ST_FILL;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_FILL: begin
                idx_d = idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs: the fill owns the write port until it finishes
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_data  = '0;
        fill_busy = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                ram_we    = 1'b1;
                ram_addr  = idx_q;
                ram_data  = rom_val;
                fill_busy = 1'b1;
            end
            ST_RUN: begin
                ram_we    = wr_en;
                ram_addr  = wr_addr;
                ram_data  = wr_data;
            end
        endcase
    end

endmodule

// File: rtl/wave_dp_ram.sv
module wave_dp_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            q <= '0;
        end else begin
            q <= cells[raddr];
        end
    end

endmodule

// File: rtl/wave_wrap_det.sv
module wave_wrap_det #(
    parameter int ADDR_W = 8
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic              wrap
);
    logic [ADDR_W-1:0] prev_q;
    logic              seen_q;

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
            wrap   <= 1'b0;
        end else begin
            prev_q <= raddr;
            seen_q <= 1'b1;
            wrap   <= seen_q && (raddr < prev_q);
        end
    end

endmodule

// File: rtl/wave_lut.sv
module wave_lut #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [ACC_W-1:0]  phase,
    output logic [DATA_W-1:0] q,
    output logic              wrap
);
    localparam int FRAC_W = ACC_W - ADDR_W;

    logic [ADDR_W-1:0] rd_addr;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic              fill_busy;
    logic              frac_unused;

    assign rd_addr     = phase[ACC_W-1 -: ADDR_W];
    assign frac_unused = ^phase[FRAC_W-1:0];

    wave_fill_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fill (
        .wclk     (wclk),
        .wrst_n   (wrst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ram_we   (ram_we),
        .ram_addr (ram_waddr),
        .ram_data (ram_wdata),
        .fill_busy(fill_busy)
    );

    wave_dp_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .wclk  (wclk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .rclk  (rclk),
        .rrst_n(rrst_n),
        .raddr (rd_addr),
        .q     (q)
    );

    wave_wrap_det #(
        .ADDR_W(ADDR_W)
    ) u_wrap (
        .rclk  (rclk),
        .rrst_n(rrst_n),
        .raddr (rd_addr),
        .wrap  (wrap)
    );

endmodule

// File: rtl/wave_lut_chk.sv
module wave_lut_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              wclk,
    input logic              wrst_n,
    input logic              rclk,
    input logic              rrst_n,
    input logic [ADDR_W-1:0] raddr,
    input logic [DATA_W-1:0] q,
    input logic              wrap,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_waddr,
    input logic              fill_busy
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W:0]   fill_cyc;
    logic [ADDR_W-1:0] p1;
    logic [ADDR_W-1:0] p2;
    logic [1:0]        seen;

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            fill_cyc <= '0;
        end else if (fill_busy) begin
            fill_cyc <= fill_cyc + 1'b1;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            p1   <= '0;
            p2   <= '0;
            seen <= '0;
        end else begin
            p1 <= raddr;
            p2 <= p1;
            if (seen != 2'd2) begin
                seen <= seen + 1'b1;
            end
        end
    end

    // R5: the fill writes consecutive addresses
    assert_fill_step_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
        (fill_busy && fill_cyc != '0) |-> (ram_waddr == ADDR_W'($past(ram_waddr) + 1'b1)));

    // R5: the fill writes on every cycle and ends within the table depth
    assert_fill_bound_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
        fill_busy |-> (ram_we && fill_cyc < (ADDR_W + 1)'(DEPTH)));

    // R4: the first sample after a read reset never flags a wrap
    assert_wrap_first_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (seen == 2'd1) |-> !wrap);

    // R4: wrap tracks a drop of the read address
    assert_wrap_order_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (seen == 2'd2) |-> (wrap == (p1 < p2)));

    // R7: outputs held clear during read reset
    assert_read_reset_R7: assert property (@(posedge rclk)
        !rrst_n |-> (q == '0 && !wrap));

endmodule

bind wave_lut wave_lut_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .wclk     (wclk),
    .wrst_n   (wrst_n),
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .raddr    (rd_addr),
    .q        (q),
    .wrap     (wrap),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .fill_busy(fill_busy)
);

// File: tb/sim_wave_lut.sv
module sim_wave_lut;

    logic        wclk;
    logic        wrst_n;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        rclk;
    logic        rrst_n;
    logic [31:0] phase;
    logic [7:0]  q;
    logic        wrap;

    int          n_chk;
    int          n_bad;
    logic [7:0]  exp_mem [256];
    logic [7:0]  prev_a;
    bit          have_prev;
    int          wrap_cnt;

    wave_lut u0 (
        .wclk   (wclk),
        .wrst_n (wrst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .phase  (phase),
        .q      (q),
        .wrap   (wrap)
    );

    initial begin
        rclk = 1'b0;
        forever #4 rclk = ~rclk;
    end

    initial begin
        wclk = 1'b0;
        #2;
        forever #4 wclk = ~wclk;
    end

    function automatic logic [7:0] ref_sine(int k);
        real v;
        v = 128.0 + 127.0 * $sin(6.283185307179586 * real'(k) / 256.0);
        return 8'($rtoi(v + 0.5));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_sine_model();
        for (int k = 0; k < 256; k++) exp_mem[k] = ref_sine(k);
    endtask

    // First sample after a read reset release: no wrap allowed (R4, R7)
    task automatic first_read(input logic [31:0] ph);
        logic [7:0] a;
        @(negedge rclk);
        rrst_n = 1'b1;
        phase  = ph;
        @(posedge rclk);
        #1;
        a = ph[31:24];
        chk("R2 first sample", q, exp_mem[a]);
        chk("R4 no wrap on first sample after reset", wrap, 0);
        prev_a    = a;
        have_prev = 1'b1;
    endtask

    task automatic read_step(input logic [31:0] ph, input string req);
        logic [7:0] a;
        bit         ew;
        @(negedge rclk);
        phase = ph;
        @(posedge rclk);
        #1;
        a  = ph[31:24];
        ew = have_prev && (a < prev_a);
        chk({req, " R2 q"}, q, exp_mem[a]);
        chk({req, " R4 wrap"}, wrap, ew);
        if (wrap) wrap_cnt++;
        prev_a    = a;
        have_prev = 1'b1;
    endtask

    task automatic write_word(input logic [7:0] a, input logic [7:0] d);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(input logic [31:0] start, input logic [31:0] inc, input int n, input string req);
        logic [31:0] acc;
        acc = start;
        for (int i = 0; i < n; i++) begin
            read_step(acc, req);
            acc = acc + inc;
        end
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] old_v;
        logic [7:0] new_v;
        n_chk     = 0;
        n_bad     = 0;
        have_prev = 1'b0;
        wrap_cnt  = 0;
        wrst_n    = 1'b0;
        rrst_n    = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = 8'h00;
        wr_data   = 8'h00;
        phase     = 32'h0;

        // R7: reset state
        repeat (3) @(posedge rclk);
        #1;
        chk("R7 q in reset", q, 0);
        chk("R7 wrap in reset", wrap, 0);

        // R5/R6: release write reset, try to write during the fill
        @(negedge wclk);
        wrst_n  = 1'b1;
        wr_en   = 1'b1;
        wr_addr = 8'h05;
        wr_data = 8'h00;
        repeat (100) @(negedge wclk);
        wr_en = 1'b0;
        repeat (170) @(negedge wclk);
        fill_sine_model();

        // R5: full sweep over the power-up sine table
        first_read(32'h0000_0000);
        sweep(32'h0100_0000, 32'h0100_0000, 255, "R5 sine table");
        chk("R6 write during fill ignored, addr 05", exp_mem[5], ref_sine(5));
        read_step(32'h05AB_CDEF, "R6 addr 05 still sine");

        // R1: load a known pattern through the write port
        for (int k = 0; k < 256; k++) begin
            write_word(8'(k), 8'(k) ^ 8'h5A);
            exp_mem[k] = 8'(k) ^ 8'h5A;
        end

        // R3: low phase bits have no effect
        read_step(32'h7700_0000, "R3 low bits zero");
        read_step(32'h77FF_FFFF, "R3 low bits ones");
        chk("R3 q independent of low bits", q, 8'h77 ^ 8'h5A);

        // R1/R2/R4: sweeps with several phase steps
        sweep(32'h0000_0000, 32'h0100_0000, 300, "R1 step 1");
        sweep(32'h0012_3456, 32'h0312_3457, 300, "R1 step odd");
        sweep(32'h0200_0000, 32'h0700_00FF, 300, "R1 step 7");
        sweep(32'h0000_0001, 32'h4000_0001, 40, "R1 step quarter");
        sweep(32'h1000_0000, 32'hC800_0000, 100, "R4 step 200");
        sweep(32'h3000_0000, 32'hFF00_0000, 100, "R4 step minus one");

        // R9: step 16 addresses from address 0 gives a wrap every 16 samples
        read_step(32'h0000_0000, "R9 start");
        wrap_cnt = 0;
        sweep(32'h1000_0000, 32'h1000_0000, 160, "R9 step 16");
        chk("R9 wrap count over 160 samples", wrap_cnt, 10);

        // R8: write the address being read
        read_step(32'h4000_0000, "R8 before write");
        old_v = exp_mem[8'h40];
        new_v = 8'hC3;
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_addr = 8'h40;
        wr_data = new_v;
        @(negedge wclk);
        wr_en = 1'b0;
        @(posedge rclk);
        #1;
        n_chk++;
        if (q != old_v && q != new_v) begin
            n_bad++;
            $display("FAIL R8 collision actual=%0h expected=%0h or %0h", q, old_v, new_v);
        end
        exp_mem[8'h40] = new_v;
        repeat (2) @(posedge rclk);
        read_step(32'h4000_0000, "R8 after write");

        // R7/R4: read reset mid-stream, then restart at a lower address
        read_step(32'hC800_0000, "R7 before reset");
        @(negedge rclk);
        rrst_n = 1'b0;
        #1;
        chk("R7 q cleared asynchronously", q, 0);
        chk("R7 wrap cleared", wrap, 0);
        repeat (2) @(posedge rclk);
        first_read(32'h0A00_0000);

        // R5: a second write reset restores the sine
        @(negedge wclk);
        wrst_n = 1'b0;
        @(negedge wclk);
        wrst_n = 1'b1;
        repeat (262) @(negedge wclk);
        fill_sine_model();
        sweep(32'h0080_0000, 32'h0300_0000, 256, "R5 refill");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule